// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register

This block captures a parallel word into a chain of stages and sends it out one bit at a time through the last stage. A level-sensitive, active-low shift/load input copies the parallel word into every stage while it is low, and any clock activity is ignored during that time. While shift/load is high, each rising edge of the logical OR of the shift clock and the clock-inhibit input moves every stage one place toward the output, and the serial input fills the first stage. The shift clock and the inhibit input therefore do the same job: a rise on either one shifts when the other is held low, and holding either one high blocks the other.

The whole block runs on one fast system clock. The shift clock and the inhibit input are treated as slow external signals. Each passes through a two-flop synchroniser, and a register clock edge is recognised when the synchronised OR goes from 0 to 1. The serial output and its complement come straight from the last stage. The reset input is asynchronous and active-low, and its release is synchronised to the system clock.

Top module: `piso_shreg`

## Requirements
- R1: While `rst_n` is low, every stage is cleared, so `qs` is 0 and `qs_n` is 1.
- R2: While `ld_n` is low, each system clock edge copies `par[i]` into stage i. Stage WIDTH-1 drives `qs`, so `qs` equals `par[WIDTH-1]` one system clock after the load edge.
- R3: While `ld_n` is low, activity on `sclk` or `inh` does not shift the register, and the loaded word stays in place.
- R4: While `ld_n` is high, a rise of (`sclk` OR `inh`) causes exactly one shift. In that shift, stage i+1 takes stage i and stage 0 takes `ser`. The shift appears on `qs` at the third system clock edge after the input rises, and not at the second.
- R5: With `sclk` held low, a rise on `inh` causes a shift, in the same way that a rise on `sclk` does with `inh` held low.
- R6: While one of `sclk` and `inh` is held high, toggling the other causes no change to the contents.
- R7: With `ld_n` high and both `sclk` and `inh` static, the contents do not change.
- R8: No shift is taken in the first cycle after `ld_n` returns high. If the combined clock is already high at that point, it must first fall and then rise again before a shift happens.
- R9: `qs_n` is always the complement of `qs`.
- R10: After a load, successive shifts present `par[WIDTH-1]`, then `par[WIDTH-2]`, and so on down to `par[0]` on `qs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| ld_n | input | 1 | Shift/load control: low loads, high allows shifting |
| sclk | input | 1 | Shift clock, sampled by the system clock |
| inh | input | 1 | Clock inhibit, sampled by the system clock and ORed with `sclk` |
| ser | input | 1 | Serial data into stage 0 |
| par | input | WIDTH | Parallel load word |
| qs | output | 1 | Serial output taken from the last stage |
| qs_n | output | 1 | Complement of `qs` |

## Verification
A load is due on `qs` one system clock after the edge on which `ld_n` is low. A shift is due three edges after `sclk` or `inh` rises: two synchroniser stages and then the stage update. The bench drives and samples on falling edges. After each operation it waits at least four edges before comparing, and it checks directly that nothing has changed two edges after a rise and that the change is present on the third. `ser` is held stable for the whole of each pulse, so the bit that is shifted in is always known.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } act_e;
endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/piso_edge_det.sv
module piso_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic ld_n,
  input  logic sclk,
  input  logic inh,
  output logic shift_en
);
  localparam int NIN = 2;

  logic [NIN-1:0]                  pin_w;
  logic [NIN-1:0][SYNC_STAGES-1:0] sync_q;
  logic [NIN-1:0][SYNC_STAGES-1:0] sync_d;
  logic [NIN-1:0]                  synced_w;
  logic                            comb_now;
  logic                            prev_q;
  logic                            prev_d;

  assign pin_w = {inh, sclk};

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      sync_d[i]   = {sync_q[i][SYNC_STAGES-2:0], pin_w[i]};
      synced_w[i] = sync_q[i][SYNC_STAGES-1];
    end
  end

  assign comb_now = |synced_w;
  // During load the previous level is forced high, so a fresh rise is needed afterwards.
  assign prev_d   = ld_n ? comb_now : 1'b1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign shift_en = ld_n & comb_now & ~prev_q;

  AST_ONE_SHIFT_PER_RISE: assert property (@(posedge clk) disable iff (!arst_n)
    shift_en |=> !shift_en); // R4
  AST_NO_SHIFT_ON_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
    (ld_n && !$past(ld_n)) |-> !shift_en); // R8
endmodule

// File: rtl/piso_core.sv
module piso_core
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  act_e             act,
  input  logic             ser,
  input  logic [WIDTH-1:0] par,
  output logic [WIDTH-1:0] stages
);
  logic [WIDTH-1:0] stages_q;
  logic [WIDTH-1:0] stages_d;
  logic             stages_en;

  always_comb begin
    stages_en = 1'b0;
    stages_d  = stages_q;
    unique case (act)
      ACT_LOAD: begin
        stages_en = 1'b1;
        stages_d  = par;
      end
      ACT_SHIFT: begin
        stages_en = 1'b1;
        stages_d  = {stages_q[WIDTH-2:0], ser};
      end
      default: begin
        stages_en = 1'b0;
        stages_d  = stages_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        stages_q <= '0;
    else if (stages_en) stages_q <= stages_d;
  end

  assign stages = stages_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!arst_n)
    (act == ACT_LOAD) |=> (stages_q == $past(par))); // R2
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    (act == ACT_SHIFT) |=> (stages_q == {$past(stages_q[WIDTH-2:0]), $past(ser)})); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!arst_n)
    (act == ACT_HOLD) |=> $stable(stages_q)); // R7
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             sclk,
  input  logic             inh,
  input  logic             ser,
  input  logic [WIDTH-1:0] par,
  output logic             qs,
  output logic             qs_n
);
  localparam int LAST = WIDTH - 1;

  logic             arst_n;
  logic             shift_en;
  act_e             act;
  logic [WIDTH-1:0] stages;

  piso_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(arst_n)
  );

  piso_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .arst_n(arst_n), .ld_n(ld_n), .sclk(sclk), .inh(inh),
    .shift_en(shift_en)
  );

  always_comb begin
    if (!ld_n)         act = ACT_LOAD;
    else if (shift_en) act = ACT_SHIFT;
    else               act = ACT_HOLD;
  end

  piso_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .arst_n(arst_n), .act(act), .ser(ser), .par(par),
    .stages(stages)
  );

  assign qs   = stages[LAST];
  assign qs_n = ~stages[LAST];

  AST_LOAD_OVERRIDES: assert property (@(posedge clk) disable iff (!arst_n)
    !ld_n |=> (qs == $past(par[LAST]))); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (qs == 1'b0)); // R1
endmodule

// File: tb/sim_piso_shreg.sv
module sim_piso_shreg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, ld_n, sclk, inh, ser;
  logic [W-1:0] par;
  logic         qs, qs_n;
  logic [W-1:0] exp_q;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2.5 clk = ~clk;

  piso_shreg #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .sclk(sclk), .inh(inh),
    .ser(ser), .par(par), .qs(qs), .qs_n(qs_n)
  );

  function automatic logic [W-1:0] shifted(logic [W-1:0] v, logic s);
    return {v[W-2:0], s};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act_v, logic exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act_v, exp_v, $time);
    end
  endtask

  task automatic chk_out(string req);
    chk(req, qs, exp_q[W-1]);
    chk("R9", qs_n, ~exp_q[W-1]);
  endtask

  task automatic do_load(logic [W-1:0] v, bit noisy);
    ld_n = 1'b0; par = v;
    step(1);
    exp_q = v;
    chk_out("R2");
    for (int k = 0; k < 6; k++) begin
      if (noisy) begin sclk = 1'($urandom); inh = 1'($urandom); end
      step(1);
      chk_out(noisy ? "R3" : "R2");
    end
    sclk = 1'b0; inh = 1'b0;
    step(3);
    ld_n = 1'b1;
    step(3);
    chk_out(noisy ? "R3" : "R2");
  endtask

  task automatic do_pulse(bit use_inh);
    ser = 1'($urandom);
    if (use_inh) inh = 1'b1; else sclk = 1'b1;
    step(4);
    exp_q = shifted(exp_q, ser);
    chk_out(use_inh ? "R5" : "R4");
    if (use_inh) inh = 1'b0; else sclk = 1'b0;
    step(4);
    chk_out(use_inh ? "R5" : "R4");
  endtask

  task automatic do_held(bit hold_inh);
    ser = 1'($urandom);
    if (hold_inh) inh = 1'b1; else sclk = 1'b1;
    step(4);
    exp_q = shifted(exp_q, ser);
    chk_out("R6");
    for (int k = 0; k < 3; k++) begin
      ser = 1'($urandom);
      if (hold_inh) sclk = ~sclk; else inh = ~inh;
      step(2);
      if (hold_inh) sclk = ~sclk; else inh = ~inh;
      step(2);
      chk_out("R6");
    end
    if (hold_inh) inh = 1'b0; else sclk = 1'b0;
    step(4);
    chk_out("R6");
  endtask

  task automatic do_release_high(logic [W-1:0] v);
    ld_n = 1'b0; par = v; sclk = 1'b1;
    step(4);
    ld_n = 1'b1;
    exp_q = v;
    step(4);
    chk_out("R8");
    sclk = 1'b0;
    step(4);
    chk_out("R8");
    do_pulse(1'b0);
  endtask

  initial begin
    rst_n = 1'b0; ld_n = 1'b1; sclk = 1'b0; inh = 1'b0; ser = 1'b0; par = '0;
    exp_q = '0;
    void'($urandom(32'd5150));
    step(3);
    chk("R1", qs, 1'b0);
    chk("R1", qs_n, 1'b1);
    rst_n = 1'b1;
    step(4);
    do_pulse(1'b0);

    // R4 latency: change due on the third edge after the rise, not the second
    do_load(8'h7F, 1'b0);
    ser = 1'b1; sclk = 1'b1;
    step(2);
    chk("R4", qs, 1'b0);
    step(1);
    chk("R4", qs, 1'b1);
    exp_q = shifted(exp_q, 1'b1);
    sclk = 1'b0;
    step(4);

    // R10 readout order
    do_load(8'hA6, 1'b0);
    for (int k = W - 1; k > 0; k--) begin
      do_pulse(1'b0);
      chk("R10", qs, exp_q[W-1]);
    end

    // R5 inhibit rise shifts with the clock low
    do_pulse(1'b1);
    do_held(1'b1);
    do_held(1'b0);
    do_release_high(8'h81);
    do_load(8'h3C, 1'b1);

    for (int op = 0; op < 150; op++) begin
      case ($urandom % 7)
        0: do_load(W'($urandom), 1'b0);
        1: do_load(W'($urandom), 1'b1);
        2: do_pulse(1'b0);
        3: do_pulse(1'b1);
        4: do_held(1'($urandom));
        5: do_release_high(W'($urandom));
        default: begin
          ser = 1'($urandom);
          step(1 + ($urandom % 6));
          chk_out("R7");
        end
      endcase
    end

    // R1 mid-run reset clears at once
    do_load(8'hFF, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1", qs, 1'b0);
    step(1);
    chk("R1", qs_n, 1'b1);
    rst_n = 1'b1;
    exp_q = '0;
    step(4);
    chk_out("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule